// File: doc/BRIEF.md
# Aliased Floating-Point Register File

This block holds the floating-point operand storage of a core. One array of 64 words of 32 bits each can be reached at three widths. A single-precision access moves one word. A double-precision access moves two adjacent words. A quad-precision access moves four adjacent words. Two combinational read ports and one clocked write port each take a 2-bit precision code and a 5-bit register specifier. Data travels on a 128-bit bus. Narrower operands sit in the low bits, and the unused high bits read as zero.

The array has two banks of 32 words. The lower bank is reachable at all three widths. The upper bank is reachable only as doubles and quads: for those widths, bit 0 of the specifier picks the bank. Within an operand, the lowest-numbered word is the most significant. A specifier and precision pair that has no storage behind it raises an error flag. Such a write changes nothing, and such a read returns zero. Every port accepts an access on every cycle, so there is no back-pressure.

Top module: `fprf_top`

## Requirements
- R1: After reset, every word is zero, so any legal read returns all zeros.
- R2: With precision code 2'b00 (single), specifier s selects lower-bank word s. Read data is in bits [31:0] and bits [127:32] are zero.
- R3: With precision code 2'b01 (double) and specifier bit 0 clear, the specifier selects lower-bank words s and s+1. Word s is read in bits [63:32], word s+1 in bits [31:0], and bits [127:64] are zero. The singles s and s+1 read back the two halves of a double written there.
- R4: With precision code 2'b01 and specifier bit 0 set, the double is upper-bank double number s[4:1], held in words 32+2·s[4:1] and 32+2·s[4:1]+1. Writing it changes no single-precision register.
- R5: With precision code 2'b10 (quad) and specifier bits [1:0] equal to 00, the quad covers lower words 4·s[4:2] through 4·s[4:2]+3, most significant first. It equals double 4·s[4:2] in bits [127:64] and double 4·s[4:2]+2 in bits [63:0].
- R6: With precision code 2'b10 and specifier bits [1:0] equal to 01, the quad covers upper words 32+4·s[4:2] through 32+4·s[4:2]+3. It aliases the upper-bank doubles given by specifiers 4·s[4:2]+1 and 4·s[4:2]+3.
- R7: A quad specifier with bit 1 set raises the error flag of its port. On a read port the data is zero. On the write port no word changes.
- R8: Precision code 2'b11 is reserved. It raises the error flag, reads return zero, and writes change no word.
- R9: A write changes only the one, two or four words it selects. All other words keep their values.
- R10: A read that selects words being written in the same cycle returns the new data for those words, and the stored data for the rest.
- R11: The two read ports are independent. Both may read different operands at different precisions in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears all words |
| rd0_prec | input | 2 | Read port 0 precision: 00 single, 01 double, 10 quad, 11 reserved |
| rd0_spec | input | 5 | Read port 0 register specifier |
| rd0_data | output | 128 | Read port 0 operand, right-aligned |
| rd0_err | output | 1 | Read port 0 illegal pair |
| rd1_prec | input | 2 | Read port 1 precision |
| rd1_spec | input | 5 | Read port 1 register specifier |
| rd1_data | output | 128 | Read port 1 operand, right-aligned |
| rd1_err | output | 1 | Read port 1 illegal pair |
| wr_en | input | 1 | Write request for this cycle |
| wr_prec | input | 2 | Write precision |
| wr_spec | input | 5 | Write register specifier |
| wr_data | input | 128 | Write operand, right-aligned |
| wr_err | output | 1 | Write request with illegal pair; nothing is written |

## Verification
A write and a read can land on the same words in the same cycle, and the read must then see the incoming value. The bench provokes this with a single-precision write to word 20. In the same cycle, port 0 reads that single and port 1 reads the double containing it. Port 1 must return the new word in its upper half and the old neighbour word in its lower half. This is judged before the clock edge, and the single is read again after the edge to confirm the stored value.

// File: rtl/fprf_pkg.sv
package fprf_pkg;
  typedef enum logic [1:0] {
    PREC_S = 2'b00,
    PREC_D = 2'b01,
    PREC_Q = 2'b10,
    PREC_X = 2'b11
  } prec_e;
endpackage

// File: rtl/fprf_decode.sv
// Maps a precision/specifier pair to a base word index and a word count.
module fprf_decode #(
  parameter int SPEC_W = 5,
  localparam int IDX_W = SPEC_W + 1
) (
  input  logic [1:0]        prec,
  input  logic [SPEC_W-1:0] spec,
  output logic              ok,
  output logic [IDX_W-1:0]  base,
  output logic [2:0]        count
);
  import fprf_pkg::*;

  always_comb begin
    ok    = 1'b0;
    base  = '0;
    count = 3'd0;
    case (prec_e'(prec))
      PREC_S: begin
        ok    = 1'b1;
        base  = {1'b0, spec};
        count = 3'd1;
      end
      PREC_D: begin
        ok    = 1'b1;
        base  = {spec[0], spec[SPEC_W-1:1], 1'b0};
        count = 3'd2;
      end
      PREC_Q: begin
        ok    = ~spec[1];
        base  = {spec[0], spec[SPEC_W-1:2], 2'b00};
        count = spec[1] ? 3'd0 : 3'd4;
      end
      default: begin
        ok    = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/fprf_store.sv
// Word array with a per-word write mask.
module fprf_store #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [DEPTH-1:0]              we_mask,
  input  logic [DEPTH-1:0][WORD_W-1:0]  we_word,
  output logic [DEPTH-1:0][WORD_W-1:0]  words
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      words <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (we_mask[i]) words[i] <= we_word[i];
      end
    end
  end
endmodule

// File: rtl/fprf_gather.sv
// Assembles a right-aligned operand from up to four words, most significant first.
module fprf_gather #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 64,
  parameter int IDX_W  = 6,
  localparam int BUS_W = 4 * WORD_W
) (
  input  logic [DEPTH-1:0][WORD_W-1:0] words,
  input  logic [1:0]                   prec,
  input  logic                         ok,
  input  logic [IDX_W-1:0]             base,
  output logic [BUS_W-1:0]             data
);
  import fprf_pkg::*;

  logic [3:0][WORD_W-1:0] pick;

  for (genvar k = 0; k < 4; k++) begin : g_pick
    assign pick[k] = words[base + IDX_W'(k)];
  end

  always_comb begin
    data = '0;
    if (ok) begin
      case (prec_e'(prec))
        PREC_S:  data[WORD_W-1:0]   = pick[0];
        PREC_D:  data[2*WORD_W-1:0] = {pick[0], pick[1]};
        PREC_Q:  data = {pick[0], pick[1], pick[2], pick[3]};
        default: data = '0;
      endcase
    end
  end
endmodule

// File: rtl/fprf_top.sv
module fprf_top #(
  parameter int WORD_W = 32,
  parameter int SPEC_W = 5,
  localparam int IDX_W = SPEC_W + 1,
  localparam int DEPTH = 2 ** IDX_W,
  localparam int BUS_W = 4 * WORD_W,
  localparam int NRD   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rd0_prec,
  input  logic [SPEC_W-1:0] rd0_spec,
  output logic [BUS_W-1:0]  rd0_data,
  output logic              rd0_err,
  input  logic [1:0]        rd1_prec,
  input  logic [SPEC_W-1:0] rd1_spec,
  output logic [BUS_W-1:0]  rd1_data,
  output logic              rd1_err,
  input  logic              wr_en,
  input  logic [1:0]        wr_prec,
  input  logic [SPEC_W-1:0] wr_spec,
  input  logic [BUS_W-1:0]  wr_data,
  output logic              wr_err
);
  logic                         wr_ok;
  logic [IDX_W-1:0]             wr_base;
  logic [2:0]                   wr_cnt;
  logic [DEPTH-1:0]             wr_mask;
  logic [DEPTH-1:0][WORD_W-1:0] wr_word;
  logic [DEPTH-1:0][WORD_W-1:0] mem;
  logic [DEPTH-1:0][WORD_W-1:0] fwd;

  fprf_decode #(.SPEC_W(SPEC_W)) u_wdec (
    .prec(wr_prec), .spec(wr_spec), .ok(wr_ok), .base(wr_base), .count(wr_cnt)
  );

  assign wr_err = wr_en & ~wr_ok;

  // Scatter: word offset within the operand picks the bus lane (offset 0 = top lane).
  for (genvar i = 0; i < DEPTH; i++) begin : g_scatter
    logic [IDX_W-1:0] off;
    logic [1:0]       lane;
    assign off        = IDX_W'(i) - wr_base;
    assign lane       = 2'(wr_cnt - 3'd1 - off[2:0]);
    assign wr_mask[i] = wr_en && wr_ok && (off < IDX_W'(wr_cnt));
    assign wr_word[i] = wr_data[lane*WORD_W +: WORD_W];
    assign fwd[i]     = wr_mask[i] ? wr_word[i] : mem[i];
  end

  fprf_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .we_mask(wr_mask), .we_word(wr_word), .words(mem)
  );

  logic [NRD-1:0][1:0]        rp_prec;
  logic [NRD-1:0][SPEC_W-1:0] rp_spec;
  logic [NRD-1:0][BUS_W-1:0]  rp_data;
  logic [NRD-1:0]             rp_ok;

  assign rp_prec = {rd1_prec, rd0_prec};
  assign rp_spec = {rd1_spec, rd0_spec};

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [IDX_W-1:0] base;
    logic [2:0]       cnt;
    logic             cnt_any;
    fprf_decode #(.SPEC_W(SPEC_W)) u_rdec (
      .prec(rp_prec[p]), .spec(rp_spec[p]), .ok(rp_ok[p]), .base(base), .count(cnt)
    );
    assign cnt_any = |cnt;
    fprf_gather #(.WORD_W(WORD_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_gath (
      .words(fwd), .prec(rp_prec[p]), .ok(rp_ok[p] & cnt_any), .base(base),
      .data(rp_data[p])
    );
  end

  assign rd0_data = rp_data[0];
  assign rd1_data = rp_data[1];
  assign rd0_err  = ~rp_ok[0];
  assign rd1_err  = ~rp_ok[1];
endmodule

// File: rtl/fprf_chk.sv
module fprf_chk #(
  parameter int WORD_W = 32,
  parameter int SPEC_W = 5,
  localparam int BUS_W = 4 * WORD_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        rd0_prec,
  input logic [SPEC_W-1:0] rd0_spec,
  input logic [BUS_W-1:0]  rd0_data,
  input logic              rd0_err,
  input logic [1:0]        rd1_prec,
  input logic [BUS_W-1:0]  rd1_data,
  input logic              rd1_err,
  input logic              wr_en,
  input logic [1:0]        wr_prec,
  input logic [SPEC_W-1:0] wr_spec,
  input logic [WORD_W-1:0] wr_lo,
  input logic              wr_err
);
  // R2
  single_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd0_prec == 2'b00 |-> rd0_data[BUS_W-1:WORD_W] == '0);

  // R3
  double_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd1_prec == 2'b01 |-> rd1_data[BUS_W-1:2*WORD_W] == '0);

  // R7
  quad_bad_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_prec == 2'b10 && rd0_spec[1]) |-> (rd0_err && rd0_data == '0));

  // R7
  quad_bad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_prec == 2'b10 && wr_spec[1]) |-> wr_err);

  // R8
  reserved_prec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd1_prec == 2'b11 |-> (rd1_err && rd1_data == '0));

  // R10
  same_cycle_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_prec == 2'b00 && rd0_prec == 2'b00 && rd0_spec == wr_spec)
      |-> rd0_data[WORD_W-1:0] == wr_lo);

  // R9
  no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && !wr_en && $stable(rd0_prec) && $stable(rd0_spec))
      |-> $stable(rd0_data));
endmodule

bind fprf_top fprf_chk #(.WORD_W(WORD_W), .SPEC_W(SPEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd0_prec(rd0_prec), .rd0_spec(rd0_spec), .rd0_data(rd0_data), .rd0_err(rd0_err),
  .rd1_prec(rd1_prec), .rd1_data(rd1_data), .rd1_err(rd1_err),
  .wr_en(wr_en), .wr_prec(wr_prec), .wr_spec(wr_spec),
  .wr_lo(wr_data[WORD_W-1:0]), .wr_err(wr_err)
);

// File: tb/fprf_top_tb.sv
`timescale 1ns/1ps
module fprf_top_tb;
  logic         clk = 0;
  logic         rst_n = 0;
  logic [1:0]   rd0_prec = 0, rd1_prec = 0, wr_prec = 0;
  logic [4:0]   rd0_spec = 0, rd1_spec = 0, wr_spec = 0;
  logic [127:0] rd0_data, rd1_data, wr_data = 0;
  logic         rd0_err, rd1_err, wr_err;
  logic         wr_en = 0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fprf_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd0_prec(rd0_prec), .rd0_spec(rd0_spec), .rd0_data(rd0_data), .rd0_err(rd0_err),
    .rd1_prec(rd1_prec), .rd1_spec(rd1_spec), .rd1_data(rd1_data), .rd1_err(rd1_err),
    .wr_en(wr_en), .wr_prec(wr_prec), .wr_spec(wr_spec), .wr_data(wr_data),
    .wr_err(wr_err)
  );

  task automatic check(input string tag, input logic [128:0] act, input logic [128:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] p, input logic [4:0] s, input logic [127:0] d);
    @(negedge clk);
    wr_en = 1; wr_prec = p; wr_spec = s; wr_data = d;
    @(posedge clk);
    #1 wr_en = 0;
  endtask

  // read on port 0, compare {err, data}
  task automatic rd(input string tag, input logic [1:0] p, input logic [4:0] s,
                    input logic err, input logic [127:0] exp);
    @(negedge clk);
    rd0_prec = p; rd0_spec = s;
    #2 check(tag, {rd0_err, rd0_data}, {err, exp});
  endtask

  task automatic t_reset;
    rd("R1 quad 0 after reset", 2'b10, 5'd0, 0, '0);
    rd("R1 quad upper after reset", 2'b10, 5'd29, 0, '0);
  endtask

  task automatic t_single;
    wr(2'b00, 5'd5, 128'h0000_0000_0000_0000_0000_0000_A5A5_0005);
    rd("R2 single 5", 2'b00, 5'd5, 0, 128'hA5A5_0005);
    rd("R3 double 4 holds single 5 low", 2'b01, 5'd4, 0, 128'h0000_0000_A5A5_0005);
  endtask

  task automatic t_double;
    wr(2'b01, 5'd6, 128'h1111_1111_2222_2222);
    rd("R3 single 6 is double high", 2'b00, 5'd6, 0, 128'h1111_1111);
    rd("R3 single 7 is double low", 2'b00, 5'd7, 0, 128'h2222_2222);
  endtask

  task automatic t_upper;
    wr(2'b01, 5'd1, 128'h3333_3333_4444_4444);
    rd("R4 upper double 1", 2'b01, 5'd1, 0, 128'h3333_3333_4444_4444);
    rd("R4 single 0 untouched", 2'b00, 5'd0, 0, '0);
    rd("R4 single 1 untouched", 2'b00, 5'd1, 0, '0);
    rd("R4 lower double 0 untouched", 2'b01, 5'd0, 0, '0);
  endtask

  task automatic t_quad;
    wr(2'b10, 5'd8, 128'h5555_5555_6666_6666_7777_7777_8888_8888);
    rd("R5 quad 8", 2'b10, 5'd8, 0, 128'h5555_5555_6666_6666_7777_7777_8888_8888);
    rd("R5 double 8 high half", 2'b01, 5'd8, 0, 128'h5555_5555_6666_6666);
    rd("R5 double 10 low half", 2'b01, 5'd10, 0, 128'h7777_7777_8888_8888);
    rd("R9 single 12 untouched", 2'b00, 5'd12, 0, '0);
    rd("R9 single 5 kept", 2'b00, 5'd5, 0, 128'hA5A5_0005);
  endtask

  task automatic t_quad_upper;
    wr(2'b10, 5'd5, 128'h9999_0000_AAAA_0000_BBBB_0000_CCCC_0000);
    rd("R6 upper double 5", 2'b01, 5'd5, 0, 128'h9999_0000_AAAA_0000);
    rd("R6 upper double 7", 2'b01, 5'd7, 0, 128'hBBBB_0000_CCCC_0000);
    rd("R6 upper double 1 kept", 2'b01, 5'd1, 0, 128'h3333_3333_4444_4444);
  endtask

  task automatic t_illegal;
    @(negedge clk);
    wr_en = 1; wr_prec = 2'b10; wr_spec = 5'd10; wr_data = '1;
    #2 check("R7 write error flag", {128'b0, wr_err}, {128'b0, 1'b1});
    @(posedge clk);
    #1 wr_en = 0;
    rd("R7 quad 8 unchanged", 2'b10, 5'd8, 0, 128'h5555_5555_6666_6666_7777_7777_8888_8888);
    rd("R7 quad 9 unchanged", 2'b10, 5'd9, 0, '0);
    rd("R7 read quad 10 error", 2'b10, 5'd10, 1, '0);
    @(negedge clk);
    wr_en = 1; wr_prec = 2'b11; wr_spec = 5'd8; wr_data = {4{32'hEEEE_EEEE}};
    #2 check("R8 write error flag", {128'b0, wr_err}, {128'b0, 1'b1});
    @(posedge clk);
    #1 wr_en = 0;
    rd("R8 quad 8 unchanged", 2'b10, 5'd8, 0, 128'h5555_5555_6666_6666_7777_7777_8888_8888);
    rd("R8 reserved read", 2'b11, 5'd8, 1, '0);
  endtask

  task automatic t_bypass;
    @(negedge clk);
    wr_en = 1; wr_prec = 2'b00; wr_spec = 5'd20; wr_data = 128'hBEEF_0020;
    rd0_prec = 2'b00; rd0_spec = 5'd20;
    rd1_prec = 2'b01; rd1_spec = 5'd20;
    #2;
    check("R10 port0 sees new single", {rd0_err, rd0_data}, {1'b0, 128'hBEEF_0020});
    check("R11 port1 double mixes new and old", {rd1_err, rd1_data},
          {1'b0, 128'hBEEF_0020_0000_0000});
    @(posedge clk);
    #1 wr_en = 0;
    rd("R10 single 20 stored", 2'b00, 5'd20, 0, 128'hBEEF_0020);
  endtask

  task automatic t_partial;
    wr(2'b00, 5'd9, 128'hC0C0_0009);
    rd("R9 quad 8 one word replaced", 2'b10, 5'd8, 0,
       128'h5555_5555_C0C0_0009_7777_7777_8888_8888);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_single();
    t_double();
    t_upper();
    t_quad();
    t_quad_upper();
    t_illegal();
    t_bypass();
    t_partial();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule